// File: doc/BRIEF.md
# Multicart Outer-Bank Memory Mapper

This block is the address-translation core of a game-cartridge multicart mapper. A standard inner bank controller with eight inner bank registers, extendable to twelve, is wrapped by four outer configuration bytes. The outer bytes select which slice of a large program ROM and pattern ROM is visible, and how many bits of each inner bank number survive into the physical bank.

The CPU writes registers through a single address/data/strobe port. The block holds the register file. From it, the block continuously drives the physical 8 KiB program bank for each of the four CPU windows (0x8000, 0xA000, 0xC000, 0xE000) and the physical 1 KiB pattern bank for each of the eight video windows. Three mapping styles are available:

- a masked multicart style, where inner numbers are trimmed to a mode-dependent width;
- an extended style, where twelve inner registers are used unmasked;
- a simple style, where the video side maps one flat 8 KiB bank.

The bank outputs are pure functions of the stored registers. Every write is therefore visible on the outputs straight after the clock edge that stores it. Two build-time variants are offered: one presets the program slice at reset, and one exchanges two bank-select codes as they are written.

Top module: `mc_bank_mapper`

## Requirements
- R1: After reset, the inner registers 0..11 hold 0x00,0x02,0x04,0x05,0x06,0x07,0x00,0x01,0xFE,0xFF,0xFF,0xFF. The outer bytes 0..3 and the bank-select byte read 0, and the RAM-control byte reads 0x80. As a result, the CPU banks are 0x00,0x01,0x3E,0x3F and video window w maps to bank w.
- R2: A write to 0x5000–0x5FFF stores into outer byte number addr[1:0], but only while RAM-control bit 6 is set. Otherwise the write changes nothing.
- R3: Writes with addr[15]=1, addr[14:13]=00 and the simple style off are decoded by addr[0]. When addr[0]=0 the data goes to the bank-select byte. When addr[0]=1 the data goes to the inner register that bank-select names: bits 2:0 normally, bits 3:0 in extended style, where an index above 11 is dropped.
- R4: The program mode is outer0[2:0], and the program mask is 0x3F shifted right by that mode. A 12-bit program base is built from these bits, high to low: outer2[5], outer2[7:6], outer0[7], outer0[3], outer1[6:0]. In masked style, each CPU bank = (inner AND mask) OR ((base×2) AND NOT mask).
- R5: In masked style, the CPU windows take inner 6, inner 7, 0xFE and 0xFF in that order. When bank-select bit 6 is set, the 0x8000 and 0xC000 windows exchange sources.
- R6: In masked style, the video mask is 0x7F if outer0[4] is set and 0xFF otherwise, and the video outer part is (outer2×8) AND NOT mask. The logical windows 0..7 take inner0 with bit 0 cleared, inner0 with bit 0 set, inner1 with bit 0 cleared, inner1 with bit 0 set, then inner 2, 3, 4 and 5. Each value is masked and ORed with the outer part.
- R7: When bank-select bit 7 is set, physical video window w shows logical window w XOR 4.
- R8: Extended style (outer3[1]=1) ORs each inner number unmasked with base×2 or with outer2×8. The fixed CPU windows then use inner 8 and inner 9, and logical video windows 1 and 3 use inner 10 and inner 11.
- R9: Simple style (outer0[6]=1) works as follows. Any write with addr[15]=1 stores only data[1:0] into a low-bank latch; the inner registers, bank select and RAM control are unchanged. Video window w maps to ((outer2 OR (latch AND m))×8)+w. m is 0 when outer3 AND 0x46 is zero; otherwise m is 1 if outer0[4] is set, else 3.
- R10: A write with addr[15]=1, addr[14:13]=01 and addr[0]=1, outside simple style, stores the RAM-control byte. Its bit 7 drives ram_enable and its bit 5 drives ram_ext.
- R11: With PRESET_OUTER1=1, reset leaves outer1 at 0x20, so the CPU banks after reset are 0x40,0x41,0x7E,0x7F.
- R12: With SWAP_SEL=1, a bank-select write of 0x46 stores 0x47 and a write of 0x47 stores 0x46.
- R13: Bank outputs reflect a write at the clock edge that stores it, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 16 | CPU address of the write |
| wr_data | input | 8 | Write data |
| prg_bank | output | 4×13 | Physical 8 KiB program bank per CPU window, index 0 = 0x8000 |
| chr_bank | output | 8×11 | Physical 1 KiB pattern bank per video window, index 0 = 0x0000 |
| ram_enable | output | 1 | Work-RAM enable from RAM-control bit 7 |
| ram_ext | output | 1 | Extended work-RAM select from RAM-control bit 5 |

## Verification
The bench builds the block twice.

The first instance uses the default parameters, with no preset and no swap. A behavioural model of the register file runs beside it, and after every write the bench compares all twelve bank outputs and both RAM bits with the model. This covers every program mode, both inversions, masked and extended styles, the write lock and simple-style latching.

The second instance has PRESET_OUTER1 and SWAP_SEL both set and its own write strobe. That brings the preset program slice after reset and the exchanged bank-select codes within reach, without disturbing the first model.

// File: rtl/mc_bank_pkg.sv
package mc_bank_pkg;

    localparam int DW         = 8;
    localparam int ADDR_W     = 16;
    localparam int NOUTER     = 4;
    localparam int NINNER     = 12;
    localparam int PRG_WIN    = 4;
    localparam int CHR_WIN    = 8;
    localparam int PRG_BASE_W = 12;
    localparam int PRG_BANK_W = PRG_BASE_W + 1;
    localparam int CHR_BANK_W = DW + 3;
    localparam int IDX_W      = $clog2(NINNER);

    typedef struct packed {
        logic [NOUTER-1:0][DW-1:0] outer;
        logic [NINNER-1:0][DW-1:0] inner;
        logic [DW-1:0]             sel;
        logic [DW-1:0]             ramc;
        logic [1:0]                latch;
    } map_state_t;

    function automatic logic [DW-1:0] inner_reset(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h02;
            2:       return 8'h04;
            3:       return 8'h05;
            4:       return 8'h06;
            5:       return 8'h07;
            6:       return 8'h00;
            7:       return 8'h01;
            8:       return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic map_state_t reset_state(input bit preset);
        map_state_t s;
        s      = '0;
        s.ramc = 8'h80;
        if (preset) s.outer[1] = 8'h20;
        for (int i = 0; i < NINNER; i++) s.inner[i] = inner_reset(i);
        return s;
    endfunction

endpackage

// File: rtl/mc_bank_regs.sv
module mc_bank_regs
    import mc_bank_pkg::*;
#(
    parameter bit PRESET_OUTER1 = 1'b0,
    parameter bit SWAP_SEL      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output map_state_t        st_q
);

    localparam map_state_t RST_VAL = reset_state(PRESET_OUTER1);

    map_state_t       st_d;
    logic [DW-1:0]    sel_in;
    logic [IDX_W-1:0] idx;
    logic             hit_outer;
    logic             hit_high;
    logic             simple_d;
    logic             ext_d;

    // Variant: exchange two bank-select codes on the way in (R12)
    generate
        if (SWAP_SEL) begin : g_swap
            always_comb begin
                sel_in = wr_data;
                if (wr_data == 8'h46)      sel_in = 8'h47;
                else if (wr_data == 8'h47) sel_in = 8'h46;
            end
        end else begin : g_plain
            assign sel_in = wr_data;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        hit_outer = wr_en && (wr_addr[15:12] == 4'h5);
        hit_high  = wr_en && wr_addr[15];
        simple_d  = st_q.outer[0][6];
        ext_d     = st_q.outer[3][1];
        idx       = ext_d ? st_q.sel[IDX_W-1:0] : {1'b0, st_q.sel[2:0]};

        if (hit_outer) begin
            if (st_q.ramc[6]) st_d.outer[wr_addr[1:0]] = wr_data;
        end else if (hit_high && simple_d) begin
            st_d.latch = wr_data[1:0];
        end else if (hit_high) begin
            case ({wr_addr[14:13], wr_addr[0]})
                3'b000: st_d.sel = sel_in;
                3'b001: if (idx < IDX_W'(NINNER)) st_d.inner[idx] = wr_data;
                3'b011: st_d.ramc = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    // R2: outer bytes do not move while the write lock is closed
    a_r2_outer_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h5 && !st_q.ramc[6]) |=> $stable(st_q.outer));

    // R9: simple-style writes leave inner registers and bank select alone
    a_r9_latch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15] && st_q.outer[0][6])
            |=> ($stable(st_q.inner) && $stable(st_q.sel) && $stable(st_q.ramc)));

    generate
        if (SWAP_SEL) begin : g_swap_chk
            // R12: code 0x46 lands as 0x47
            a_r12_swap_46: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr[15:13] == 3'b100 && !wr_addr[0]
                 && !st_q.outer[0][6] && wr_data == 8'h46) |=> (st_q.sel == 8'h47));
        end
    endgenerate

endmodule

// File: rtl/mc_bank_prg.sv
module mc_bank_prg
    import mc_bank_pkg::*;
(
    input  map_state_t                           st,
    output logic [PRG_WIN-1:0][PRG_BANK_W-1:0]   prg_bank
);

    logic [PRG_BASE_W-1:0]           base;
    logic [PRG_BANK_W-1:0]           outer_sh;
    logic [PRG_BANK_W-1:0]           mask;
    logic [5:0]                      mask6;
    logic                            ext;
    logic                            inv;
    logic [PRG_WIN-1:0][DW-1:0]      logical;

    always_comb begin
        base     = {st.outer[2][5], st.outer[2][7:6], st.outer[0][7],
                    st.outer[0][3], st.outer[1][6:0]};
        outer_sh = {base, 1'b0};
        mask6    = 6'h3F >> st.outer[0][2:0];
        mask     = PRG_BANK_W'(mask6);
        ext      = st.outer[3][1];
        inv      = st.sel[6];

        logical[0] = st.inner[6];
        logical[1] = st.inner[7];
        logical[2] = ext ? st.inner[8] : 8'hFE;
        logical[3] = ext ? st.inner[9] : 8'hFF;
    end

    generate
        for (genvar k = 0; k < PRG_WIN; k++) begin : g_win
            logic [DW-1:0] src;
            always_comb begin
                if (k == 0 || k == 2) src = inv ? logical[k ^ 2] : logical[k];
                else                  src = logical[k];
                if (ext) prg_bank[k] = PRG_BANK_W'(src) | outer_sh;
                else     prg_bank[k] = (PRG_BANK_W'(src) & mask) | (outer_sh & ~mask);
            end
        end
    endgenerate

endmodule

// File: rtl/mc_bank_chr.sv
module mc_bank_chr
    import mc_bank_pkg::*;
(
    input  map_state_t                           st,
    output logic [CHR_WIN-1:0][CHR_BANK_W-1:0]   chr_bank
);

    logic                            ext;
    logic                            simple;
    logic                            inv;
    logic [DW-1:0]                   mask;
    logic [CHR_BANK_W-1:0]           outer_sh;
    logic [CHR_BANK_W-1:0]           outer_part;
    logic [1:0]                      lmask;
    logic [CHR_BANK_W-1:0]           flat_base;
    logic [CHR_WIN-1:0][DW-1:0]      logical;

    always_comb begin
        ext        = st.outer[3][1];
        simple     = st.outer[0][6];
        inv        = st.sel[7];
        mask       = st.outer[0][4] ? 8'h7F : 8'hFF;
        outer_sh   = {st.outer[2], 3'b000};
        outer_part = outer_sh & ~CHR_BANK_W'(mask);
        if ((st.outer[3] & 8'h46) == 8'h00) lmask = 2'd0;
        else                                lmask = st.outer[0][4] ? 2'd1 : 2'd3;
        flat_base  = {st.outer[2] | {6'b0, st.latch & lmask}, 3'b000};

        if (ext) begin
            logical[0] = st.inner[0];
            logical[1] = st.inner[10];
            logical[2] = st.inner[1];
            logical[3] = st.inner[11];
        end else begin
            logical[0] = st.inner[0] & 8'hFE;
            logical[1] = st.inner[0] | 8'h01;
            logical[2] = st.inner[1] & 8'hFE;
            logical[3] = st.inner[1] | 8'h01;
        end
        for (int i = 4; i < CHR_WIN; i++) logical[i] = st.inner[i-2];
    end

    generate
        for (genvar w = 0; w < CHR_WIN; w++) begin : g_win
            logic [2:0]    lw;
            logic [DW-1:0] src;
            always_comb begin
                lw  = 3'(w) ^ {inv, 2'b00};
                src = logical[lw];
                if (simple)   chr_bank[w] = flat_base | CHR_BANK_W'(w);
                else if (ext) chr_bank[w] = CHR_BANK_W'(src) | outer_sh;
                else          chr_bank[w] = CHR_BANK_W'(src & mask) | outer_part;
            end
        end
    endgenerate

endmodule

// File: rtl/mc_bank_mapper.sv
module mc_bank_mapper
    import mc_bank_pkg::*;
#(
    parameter bit PRESET_OUTER1 = 1'b0,
    parameter bit SWAP_SEL      = 1'b0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [15:0]                          wr_addr,
    input  logic [7:0]                           wr_data,
    output logic [3:0][12:0]                     prg_bank,
    output logic [7:0][10:0]                     chr_bank,
    output logic                                 ram_enable,
    output logic                                 ram_ext
);

    map_state_t st_q;

    mc_bank_regs #(
        .PRESET_OUTER1 (PRESET_OUTER1),
        .SWAP_SEL      (SWAP_SEL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .st_q    (st_q)
    );

    mc_bank_prg u_prg (
        .st       (st_q),
        .prg_bank (prg_bank)
    );

    mc_bank_chr u_chr (
        .st       (st_q),
        .chr_bank (chr_bank)
    );

    assign ram_enable = st_q.ramc[7];
    assign ram_ext    = st_q.ramc[5];

    // R9: simple style gives eight consecutive 1 KiB banks
    a_r9_flat_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.outer[0][6] |-> (chr_bank[7] == chr_bank[0] + 11'd7));

    // R5: uninverted masked style puts 0xFE and 0xFF side by side at the top
    a_r5_fixed_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.outer[3][1] && !st_q.sel[6]) |-> (prg_bank[3][12:1] == prg_bank[2][12:1]));

    // R5: the 0xA000 window is never affected by the swap bit
    a_r5_a000_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(st_q.inner) && $stable(st_q.outer)) |-> $stable(prg_bank[1]));

endmodule

// File: tb/mc_bank_mapper_bench.sv
`timescale 1ns/1ps
module mc_bank_mapper_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_en_v = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0][12:0] prg_bank, prg_v;
    logic [7:0][10:0] chr_bank, chr_v;
    logic ram_enable, ram_ext, ram_en_v, ram_ext_v;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mc_bank_mapper u_mc_bank_mapper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .ram_enable(ram_enable), .ram_ext(ram_ext));

    mc_bank_mapper #(.PRESET_OUTER1(1'b1), .SWAP_SEL(1'b1)) u_mc_bank_mapper_var (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_v), .wr_addr(wr_addr), .wr_data(wr_data),
        .prg_bank(prg_v), .chr_bank(chr_v), .ram_enable(ram_en_v), .ram_ext(ram_ext_v));

    // behavioural model of the default instance
    logic [7:0] mo [4];
    logic [7:0] mi [12];
    logic [7:0] msel, mram;
    logic [1:0] mlat;

    task automatic model_reset();
        logic [7:0] rv [12] = '{8'h00,8'h02,8'h04,8'h05,8'h06,8'h07,8'h00,8'h01,8'hFE,8'hFF,8'hFF,8'hFF};
        for (int i = 0; i < 4; i++) mo[i] = 8'h00;
        for (int i = 0; i < 12; i++) mi[i] = rv[i];
        msel = 8'h00; mram = 8'h80; mlat = 2'd0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        int idx;
        if (a[15:12] == 4'h5) begin
            if (mram[6]) mo[a[1:0]] = d;
        end else if (a[15] && mo[0][6]) begin
            mlat = d[1:0];
        end else if (a[15] && a[14:13] == 2'b00) begin
            if (!a[0]) msel = d;
            else begin
                idx = mo[3][1] ? int'(msel[3:0]) : int'(msel[2:0]);
                if (idx < 12) mi[idx] = d;
            end
        end else if (a[15] && a[14:13] == 2'b01 && a[0]) begin
            mram = d;
        end
    endtask

    function automatic logic [12:0] exp_prg(input int k);
        logic [11:0] base;
        logic [12:0] ob, mk;
        logic ext, inv;
        logic [7:0] v;
        base = {mo[2][5], mo[2][7:6], mo[0][7], mo[0][3], mo[1][6:0]};
        ob = {base, 1'b0};
        mk = 13'(8'h3F >> mo[0][2:0]);
        ext = mo[3][1]; inv = msel[6];
        case (k)
            0:       v = inv ? (ext ? mi[8] : 8'hFE) : mi[6];
            1:       v = mi[7];
            2:       v = inv ? mi[6] : (ext ? mi[8] : 8'hFE);
            default: v = ext ? mi[9] : 8'hFF;
        endcase
        return ext ? (13'(v) | ob) : ((13'(v) & mk) | (ob & ~mk));
    endfunction

    function automatic logic [10:0] exp_chr(input int w);
        logic [1:0] m;
        logic [7:0] v, mk;
        logic [10:0] o2s;
        int lw;
        if (mo[0][6]) begin
            m = ((mo[3] & 8'h46) == 0) ? 2'd0 : (mo[0][4] ? 2'd1 : 2'd3);
            return {mo[2] | {6'b0, mlat & m}, 3'b000} + 11'(w);
        end
        lw = w ^ (msel[7] ? 4 : 0);
        mk = mo[0][4] ? 8'h7F : 8'hFF;
        o2s = {mo[2], 3'b000};
        if (mo[3][1]) begin
            case (lw)
                0: v = mi[0]; 1: v = mi[10]; 2: v = mi[1]; 3: v = mi[11];
                default: v = mi[lw-2];
            endcase
            return 11'(v) | o2s;
        end
        case (lw)
            0: v = mi[0] & 8'hFE; 1: v = mi[0] | 8'h01;
            2: v = mi[1] & 8'hFE; 3: v = mi[1] | 8'h01;
            default: v = mi[lw-2];
        endcase
        return 11'(v & mk) | (o2s & ~11'(mk));
    endfunction

    task automatic cmp_all(input string tag);
        bit bad = 0;
        n_chk++;
        for (int k = 0; k < 4; k++)
            if (prg_bank[k] !== exp_prg(k)) begin
                bad = 1;
                $display("FAIL %s prg_bank[%0d] actual %h expected %h", tag, k, prg_bank[k], exp_prg(k));
            end
        for (int w = 0; w < 8; w++)
            if (chr_bank[w] !== exp_chr(w)) begin
                bad = 1;
                $display("FAIL %s chr_bank[%0d] actual %h expected %h", tag, w, chr_bank[w], exp_chr(w));
            end
        if (ram_enable !== mram[7] || ram_ext !== mram[5]) begin
            bad = 1;
            $display("FAIL %s R10 ram bits actual %b%b expected %b%b", tag, ram_enable, ram_ext, mram[7], mram[5]);
        end
        if (bad) n_fail++;
    endtask

    task automatic check_one(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one write on the default instance; outputs checked one edge later (R13)
    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        cmp_all(tag);
    endtask

    task automatic var_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en_v = 1'b1;
        @(negedge clk);
        wr_en_v = 1'b0;
    endtask

    localparam int NV = 34;
    // {address, data}; requirements touched noted per group
    localparam logic [23:0] VEC [NV] = '{
        {16'hA001, 8'hC0},                                           // R10 open lock
        {16'h8000, 8'h06}, {16'h8001, 8'h2A},                        // R3
        {16'h8000, 8'h07}, {16'h8001, 8'h13},                        // R3
        {16'h5001, 8'h05},                                           // R4 base
        {16'h5000, 8'h01},                                           // R4 mode 1
        {16'h8000, 8'h46},                                           // R5 swap
        {16'h5000, 8'h8A},                                           // R4 scattered bits
        {16'h5002, 8'hE0},                                           // R4 R6 outer2
        {16'h8000, 8'h80}, {16'h8001, 8'h35},                        // R7
        {16'h8000, 8'h02}, {16'h8001, 8'h77},                        // R6
        {16'h5000, 8'h12},                                           // R6 mask 7F
        {16'h5003, 8'h02},                                           // R8 on
        {16'h8000, 8'h08}, {16'h8001, 8'h55},                        // R8 inner8
        {16'h8000, 8'h0A}, {16'h8001, 8'h66},                        // R8 inner10
        {16'h8000, 8'h0B}, {16'h8001, 8'h0C},                        // R8 inner11
        {16'h8000, 8'h0D}, {16'h8001, 8'h99},                        // R3 index 13 dropped
        {16'h5003, 8'h00},
        {16'hA001, 8'h80}, {16'h5001, 8'h7F},                        // R2 locked write
        {16'hA001, 8'hC0},
        {16'h5000, 8'h40}, {16'h5003, 8'h40},                        // R9 simple style
        {16'h9000, 8'h03},                                           // R9 latch
        {16'h5000, 8'h50},                                           // R9 m=1
        {16'hA001, 8'h12},                                           // R9 no ram write
        {16'h5000, 8'h00}
    };

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R1 reset state");
        check_one("R1 prg2 after reset", prg_bank[2], 13'h03E);
        check_one("R11 preset prg0", prg_v[0], 13'h040);
        check_one("R11 preset prg1", prg_v[1], 13'h041);
        check_one("R11 preset prg3", prg_v[3], 13'h07F);

        // R12 variant: 0x46 stored as 0x47, so the data lands in inner 7
        var_write(16'h8000, 8'h46);
        var_write(16'h8001, 8'h15);
        check_one("R12 swapped target prg1", prg_v[1], 13'h055);
        check_one("R12 inner6 untouched prg2", prg_v[2], 13'h040);
        check_one("R12 inversion kept prg0", prg_v[0], 13'h07E);

        for (int i = 0; i < NV; i++)
            do_write(VEC[i][23:8], VEC[i][7:0], "R2-table");

        // sweep: R4 all modes, R5 both inversions, R8 both styles
        do_write(16'h5002, 8'hA0, "R4 sweep outer2");
        do_write(16'h5001, 8'h6B, "R4 sweep outer1");
        for (int ext = 0; ext < 2; ext++)
            for (int inv = 0; inv < 2; inv++)
                for (int mode = 0; mode < 8; mode++) begin
                    do_write(16'h5003, 8'(ext << 1), "R8 sweep style");
                    do_write(16'h8000, 8'(inv << 6) | 8'h06, "R5 sweep select");
                    do_write(16'h8001, 8'(8'hC5 + mode), "R3 sweep inner6");
                    do_write(16'h5000, 8'h88 | 8'(mode), "R4 sweep mode");
                end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule